// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and calendar date as a chain of packed-BCD counters: seconds, minutes, hours in 24-hour form, a day-of-week number, day of month, month, two-digit year and a two-digit century. A one-hertz enable pulse, generated elsewhere from a divided clock, advances the chain by one second. Each field carries into the next when it rolls over. The day-of-month limit follows the current month, and February takes its length from the current year.

Software sets the time by presenting a complete set of field values together with a load strobe. All eight counters take those values on the same clock edge. A stop control freezes counting without touching the stored values. This lets a holding register set or a bus block upstream suspend the clock or reseed it.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day-of-week 01, date 01, month 01, year 00, century 00, each as one byte of packed BCD (tens digit in bits 7:4, units digit in bits 3:0).
- R2: Each tick with stop low and load low advances seconds by one in BCD (…09 goes to …10). Seconds 59 wraps to 00 and advances minutes.
- R3: Minutes wrap from 59 to 00 and advance hours. Hours wrap from 23 to 00 and advance both the day-of-week and date fields.
- R4: Day-of-week steps only when hours wrap at midnight, and it goes from 07 back to 01.
- R5: Date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, and after 31 in every other month except 02. Month wraps from 12 to 01 and advances the year.
- R6: In month 02 the last date is 29 when the two-digit year value is divisible by 4 (00, 04, …, 96), and 28 otherwise.
- R7: Year wraps from 99 to 00 and advances the century. Century wraps from 39 to 00.
- R8: While stop is high, ticks have no effect and all fields hold.
- R9: With load high, every field takes its load value on that edge, whatever the tick and stop inputs are.
- R10: An illegal value never locks a field. On an increment, a value whose packed code is at or above the field's last value wraps to the first value and carries. Otherwise a units digit of 9 or more goes to 0 and the tens digit goes up by one.
- R11: With tick low and load low, all fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-hertz advance enable, one clock wide |
| osc_stop_i | input | 1 | Freezes counting while high |
| load_i | input | 1 | Parallel load strobe |
| ld_sec_i | input | 8 | Seconds load value |
| ld_min_i | input | 8 | Minutes load value |
| ld_hour_i | input | 8 | Hours load value |
| ld_dow_i | input | 8 | Day-of-week load value |
| ld_date_i | input | 8 | Date load value |
| ld_mon_i | input | 8 | Month load value |
| ld_year_i | input | 8 | Year load value |
| ld_cent_i | input | 8 | Century load value |
| sec_o | output | 8 | Live seconds |
| min_o | output | 8 | Live minutes |
| hour_o | output | 8 | Live hours |
| dow_o | output | 8 | Live day-of-week |
| date_o | output | 8 | Live date |
| mon_o | output | 8 | Live month |
| year_o | output | 8 | Live year |
| cent_o | output | 8 | Live century |

## Verification
Random legal calendar states, weighted toward 59-second, 23-hour and last-of-month values, are loaded and then ticked with the stop input toggled at random. This separates correct carry chains from ones that drop or double a carry, and it exposes stop leakage. Directed starts at 28 and 29 February in leap and common years, at 30 April, and at 31 December 23:59:59 in year 99 of century 39 tell apart a month table or leap rule that is off by one day. Loads with a coincident tick check load priority. Loaded illegal codes check that a field still reaches its rollover.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int FIELD_W = 8;
   localparam int NIB_W   = FIELD_W / 2;

   // packed BCD constants shared by the chain
   localparam logic [FIELD_W-1:0] BCD_00 = 8'h00;
   localparam logic [FIELD_W-1:0] BCD_01 = 8'h01;
   localparam logic [FIELD_W-1:0] BCD_12 = 8'h12;
   localparam logic [FIELD_W-1:0] BCD_23 = 8'h23;
   localparam logic [FIELD_W-1:0] BCD_59 = 8'h59;
   localparam logic [FIELD_W-1:0] BCD_99 = 8'h99;

   // last value of the three time-of-day stages, index 0 = seconds
   function automatic logic [FIELD_W-1:0] tod_last(input int idx);
      return (idx == 2) ? BCD_23 : BCD_59;
   endfunction
endpackage

// File: rtl/cal_bcd_pair.sv
module cal_bcd_pair #(
   parameter int                FIELD_W = 8,
   parameter logic [FIELD_W-1:0] RST_VAL = '0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               inc_i,
   input  logic               load_i,
   input  logic [FIELD_W-1:0] ld_val_i,
   input  logic [FIELD_W-1:0] first_i,
   input  logic [FIELD_W-1:0] last_i,
   output logic [FIELD_W-1:0] val_o,
   output logic               wrap_o
);
   localparam int NIB_W = FIELD_W / 2;

   if (FIELD_W % 2 != 0) begin : g_bad_width
      $error("cal_bcd_pair: FIELD_W must hold two whole digits");
   end

   logic [FIELD_W-1:0] val_q, val_nxt;
   logic               at_end;

   assign at_end = (val_q >= last_i);

   always_comb begin
      if (at_end)
         val_nxt = first_i;
      else if (val_q[NIB_W-1:0] >= NIB_W'(9))
         val_nxt = {val_q[FIELD_W-1:NIB_W] + NIB_W'(1), {NIB_W{1'b0}}};
      else
         val_nxt = val_q + FIELD_W'(1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     val_q <= RST_VAL;
      else if (load_i) val_q <= ld_val_i;
      else if (inc_i)  val_q <= val_nxt;
   end

   assign val_o  = val_q;
   assign wrap_o = inc_i & ~load_i & at_end;

   // R11
   hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !load_i) |=> $stable(val_o));
   // R9
   load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (val_o == $past(ld_val_i)));
   // R10
   wrap_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (val_o == $past(first_i)));
endmodule

// File: rtl/cal_month_limit.sv
module cal_month_limit #(
   parameter int FIELD_W = 8
) (
   input  logic [FIELD_W-1:0] mon_i,
   input  logic [FIELD_W-1:0] year_i,
   output logic               leap_o,
   output logic [FIELD_W-1:0] last_date_o
);
   localparam int NIB_W = FIELD_W / 2;

   logic [NIB_W-1:0] units;
   logic             tens_odd;

   assign units    = year_i[NIB_W-1:0];
   assign tens_odd = year_i[NIB_W];

   // BCD year divisible by 4: even tens with units 0/4/8, odd tens with 2/6
   always_comb begin
      if (tens_odd)
         leap_o = (units == NIB_W'(2)) || (units == NIB_W'(6));
      else
         leap_o = (units == NIB_W'(0)) || (units == NIB_W'(4)) || (units == NIB_W'(8));
   end

   always_comb begin
      unique case (mon_i)
         8'h02:                      last_date_o = leap_o ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
         default:                    last_date_o = 8'h31;
      endcase
   end
endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter #(
   parameter int                FIELD_W   = cal_pkg::FIELD_W,
   parameter logic [FIELD_W-1:0] CENT_LAST = 8'h39,
   parameter logic [FIELD_W-1:0] DOW_LAST  = 8'h07
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               tick_i,
   input  logic               osc_stop_i,
   input  logic               load_i,
   input  logic [FIELD_W-1:0] ld_sec_i,
   input  logic [FIELD_W-1:0] ld_min_i,
   input  logic [FIELD_W-1:0] ld_hour_i,
   input  logic [FIELD_W-1:0] ld_dow_i,
   input  logic [FIELD_W-1:0] ld_date_i,
   input  logic [FIELD_W-1:0] ld_mon_i,
   input  logic [FIELD_W-1:0] ld_year_i,
   input  logic [FIELD_W-1:0] ld_cent_i,
   output logic [FIELD_W-1:0] sec_o,
   output logic [FIELD_W-1:0] min_o,
   output logic [FIELD_W-1:0] hour_o,
   output logic [FIELD_W-1:0] dow_o,
   output logic [FIELD_W-1:0] date_o,
   output logic [FIELD_W-1:0] mon_o,
   output logic [FIELD_W-1:0] year_o,
   output logic [FIELD_W-1:0] cent_o
);
   import cal_pkg::*;

   localparam int TOD_N = 3;
   localparam int NIB_W = FIELD_W / 2;

   if (FIELD_W != cal_pkg::FIELD_W) begin : g_bad_width
      $error("bcd_calendar_counter: FIELD_W must be two BCD digits");
   end
   if (CENT_LAST[NIB_W-1:0] > 9 || CENT_LAST[FIELD_W-1:NIB_W] > 9) begin : g_bad_cent
      $error("bcd_calendar_counter: CENT_LAST is not packed BCD");
   end
   if (DOW_LAST < 8'h02 || DOW_LAST > 8'h09) begin : g_bad_dow
      $error("bcd_calendar_counter: DOW_LAST out of range");
   end

   logic step;
   assign step = tick_i & ~osc_stop_i & ~load_i;

   // time-of-day stages: seconds, minutes, hours
   logic [FIELD_W-1:0] tod_ld  [TOD_N];
   logic [FIELD_W-1:0] tod_val [TOD_N];
   logic               tod_wrap[TOD_N];

   assign tod_ld[0] = ld_sec_i;
   assign tod_ld[1] = ld_min_i;
   assign tod_ld[2] = ld_hour_i;

   for (genvar i = 0; i < TOD_N; i++) begin : g_tod
      logic inc;
      if (i == 0) begin : g_first
         assign inc = step;
      end else begin : g_next
         assign inc = tod_wrap[i-1];
      end
      cal_bcd_pair #(.FIELD_W(FIELD_W), .RST_VAL(BCD_00)) u_stage (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .inc_i   (inc),
         .load_i  (load_i),
         .ld_val_i(tod_ld[i]),
         .first_i (BCD_00),
         .last_i  (tod_last(i)),
         .val_o   (tod_val[i]),
         .wrap_o  (tod_wrap[i])
      );
   end

   logic midnight;
   assign midnight = tod_wrap[TOD_N-1];

   // day of week runs beside the date, both stepped at midnight
   logic dow_wrap;
   cal_bcd_pair #(.FIELD_W(FIELD_W), .RST_VAL(BCD_01)) u_dow (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (midnight),
      .load_i  (load_i),
      .ld_val_i(ld_dow_i),
      .first_i (BCD_01),
      .last_i  (DOW_LAST),
      .val_o   (dow_o),
      .wrap_o  (dow_wrap)
   );

   logic [FIELD_W-1:0] last_date;
   logic               leap;
   logic               date_wrap, mon_wrap, year_wrap, cent_wrap;

   cal_month_limit #(.FIELD_W(FIELD_W)) u_limit (
      .mon_i      (mon_o),
      .year_i     (year_o),
      .leap_o     (leap),
      .last_date_o(last_date)
   );

   cal_bcd_pair #(.FIELD_W(FIELD_W), .RST_VAL(BCD_01)) u_date (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (midnight),
      .load_i  (load_i),
      .ld_val_i(ld_date_i),
      .first_i (BCD_01),
      .last_i  (last_date),
      .val_o   (date_o),
      .wrap_o  (date_wrap)
   );

   cal_bcd_pair #(.FIELD_W(FIELD_W), .RST_VAL(BCD_01)) u_mon (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (date_wrap),
      .load_i  (load_i),
      .ld_val_i(ld_mon_i),
      .first_i (BCD_01),
      .last_i  (BCD_12),
      .val_o   (mon_o),
      .wrap_o  (mon_wrap)
   );

   cal_bcd_pair #(.FIELD_W(FIELD_W), .RST_VAL(BCD_00)) u_year (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (mon_wrap),
      .load_i  (load_i),
      .ld_val_i(ld_year_i),
      .first_i (BCD_00),
      .last_i  (BCD_99),
      .val_o   (year_o),
      .wrap_o  (year_wrap)
   );

   cal_bcd_pair #(.FIELD_W(FIELD_W), .RST_VAL(BCD_00)) u_cent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (year_wrap),
      .load_i  (load_i),
      .ld_val_i(ld_cent_i),
      .first_i (BCD_00),
      .last_i  (CENT_LAST),
      .val_o   (cent_o),
      .wrap_o  (cent_wrap)
   );

   assign sec_o  = tod_val[0];
   assign min_o  = tod_val[1];
   assign hour_o = tod_val[2];

   // R8
   stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (osc_stop_i && !load_i) |=>
         $stable({sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o, cent_o}));
   // R4
   dow_midnight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!load_i) && (dow_o != $past(dow_o))) |->
         (hour_o == BCD_00 && min_o == BCD_00 && sec_o == BCD_00));
   // R6
   feb_leap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!load_i) && mon_o == 8'h02 && date_o == 8'h29 && $past(date_o) == 8'h28)
         |-> leap);
   // R7
   cent_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!load_i) && (cent_o != $past(cent_o))) |-> (year_o == BCD_00));
   // R3
   date_with_hour_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!load_i) && (date_o != $past(date_o))) |-> (hour_o == BCD_00));
endmodule

// File: tb/bcd_calendar_counter_tb_top.sv
module bcd_calendar_counter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, stop = 1'b0, load = 1'b0;
   logic [7:0] l_sec = 0, l_min = 0, l_hr = 0, l_dow = 0, l_date = 0, l_mon = 0, l_yr = 0, l_cen = 0;
   logic [7:0] sec, mi, hr, dow, date, mon, yr, cen;

   int checks = 0, fails = 0;
   int e_s, e_mi, e_h, e_w, e_d, e_mo, e_y, e_c;

   always #4 clk = ~clk;

   bcd_calendar_counter dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .osc_stop_i(stop), .load_i(load),
      .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hr), .ld_dow_i(l_dow),
      .ld_date_i(l_date), .ld_mon_i(l_mon), .ld_year_i(l_yr), .ld_cent_i(l_cen),
      .sec_o(sec), .min_o(mi), .hour_o(hr), .dow_o(dow), .date_o(date),
      .mon_o(mon), .year_o(yr), .cent_o(cen));

   function automatic int b2i(logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction
   function automatic logic [7:0] i2b(int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction
   function automatic int mlen(int m, int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic chk(string tag, string fld, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, fld, act, exp);
      end
   endtask

   task automatic cmp_all(string tag);
      chk(tag, "sec", sec, i2b(e_s));   chk(tag, "min", mi, i2b(e_mi));
      chk(tag, "hour", hr, i2b(e_h));   chk(tag, "dow", dow, i2b(e_w));
      chk(tag, "date", date, i2b(e_d)); chk(tag, "mon", mon, i2b(e_mo));
      chk(tag, "year", yr, i2b(e_y));   chk(tag, "cent", cen, i2b(e_c));
   endtask

   task automatic model(bit t, bit st, bit ld);
      if (ld) begin
         e_s = b2i(l_sec); e_mi = b2i(l_min); e_h = b2i(l_hr); e_w = b2i(l_dow);
         e_d = b2i(l_date); e_mo = b2i(l_mon); e_y = b2i(l_yr); e_c = b2i(l_cen);
      end else if (t && !st) begin
         e_s++;
         if (e_s == 60) begin
            e_s = 0; e_mi++;
            if (e_mi == 60) begin
               e_mi = 0; e_h++;
               if (e_h == 24) begin
                  e_h = 0;
                  e_w = (e_w == 7) ? 1 : e_w + 1;
                  e_d++;
                  if (e_d > mlen(e_mo, e_y)) begin
                     e_d = 1; e_mo++;
                     if (e_mo == 13) begin
                        e_mo = 1; e_y++;
                        if (e_y == 100) begin
                           e_y = 0; e_c = (e_c == 39) ? 0 : e_c + 1;
                        end
                     end
                  end
               end
            end
         end
      end
   endtask

   // drive at falling edge, sample 2 ns after the rising edge
   task automatic cyc(bit t, bit st, bit ld, bit use_model = 1'b1);
      @(negedge clk);
      tick = t; stop = st; load = ld;
      @(posedge clk);
      #2;
      if (use_model) model(t, st, ld);
   endtask

   task automatic set_ld(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] w,
                         logic [7:0] d, logic [7:0] mo, logic [7:0] y, logic [7:0] c);
      l_sec = s; l_min = m; l_hr = h; l_dow = w; l_date = d; l_mon = mo; l_yr = y; l_cen = c;
   endtask

   task automatic seed(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] w,
                       logic [7:0] d, logic [7:0] mo, logic [7:0] y, logic [7:0] c);
      set_ld(s, m, h, w, d, mo, y, c);
      cyc(1'b0, 1'b0, 1'b1);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #2;
      e_s = 0; e_mi = 0; e_h = 0; e_w = 1; e_d = 1; e_mo = 1; e_y = 0; e_c = 0;
      cmp_all("R1 reset");

      cyc(1'b0, 1'b0, 1'b0); cmp_all("R11 idle");
      repeat (12) cyc(1'b1, 1'b0, 1'b0);
      cmp_all("R2 count");

      seed(8'h59, 8'h59, 8'h22, 8'h03, 8'h10, 8'h05, 8'h44, 8'h20);
      cyc(1'b1, 1'b0, 1'b0); cmp_all("R3 hour carry");

      seed(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h10, 8'h20);
      cyc(1'b1, 1'b0, 1'b0); cmp_all("R4 dow wrap");

      seed(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10, 8'h20);
      cyc(1'b1, 1'b0, 1'b0); cmp_all("R5 april end");
      seed(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h10, 8'h20);
      cyc(1'b1, 1'b0, 1'b0); cmp_all("R5 january 30");

      seed(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24, 8'h20);
      cyc(1'b1, 1'b0, 1'b0); cmp_all("R6 leap feb 28");
      seed(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h20);
      cyc(1'b1, 1'b0, 1'b0); cmp_all("R6 common feb 28");
      seed(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h00, 8'h20);
      cyc(1'b1, 1'b0, 1'b0); cmp_all("R6 leap year 00");

      seed(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99, 8'h39);
      cyc(1'b1, 1'b0, 1'b0); cmp_all("R7 century wrap");
      seed(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99, 8'h19);
      cyc(1'b1, 1'b0, 1'b0); cmp_all("R7 century step");

      repeat (5) cyc(1'b1, 1'b1, 1'b0);
      cmp_all("R8 stopped");

      set_ld(8'h12, 8'h34, 8'h05, 8'h04, 8'h17, 8'h08, 8'h56, 8'h21);
      cyc(1'b1, 1'b0, 1'b1); cmp_all("R9 load over tick");
      set_ld(8'h33, 8'h22, 8'h11, 8'h02, 8'h09, 8'h10, 8'h01, 8'h05);
      cyc(1'b1, 1'b1, 1'b1); cmp_all("R9 load while stopped");

      // R10 illegal codes: checked against stated rule, not the model
      set_ld(8'h7A, 8'h05, 8'h10, 8'h02, 8'h10, 8'h05, 8'h10, 8'h20);
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R10", "sec", sec, 8'h00); chk("R10", "min", mi, 8'h06);
      set_ld(8'h59, 8'h4B, 8'h10, 8'h02, 8'h10, 8'h05, 8'h10, 8'h20);
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R10", "min", mi, 8'h50); chk("R10", "hour", hr, 8'h10);
      set_ld(8'h59, 8'h59, 8'h2F, 8'h03, 8'h10, 8'h05, 8'h10, 8'h20);
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R10", "hour", hr, 8'h00); chk("R10", "dow", dow, 8'h04);
      chk("R10", "date", date, 8'h11);

      // constrained random: legal states weighted to rollover edges
      for (int it = 0; it < 250; it++) begin
         int s, m, h, w, d, mo, y, c, n;
         s  = ($urandom % 2) ? 59 : int'($urandom % 60);
         m  = ($urandom % 2) ? 59 : int'($urandom % 60);
         h  = ($urandom % 2) ? 23 : int'($urandom % 24);
         w  = 1 + int'($urandom % 7);
         mo = 1 + int'($urandom % 12);
         y  = ($urandom % 3 == 0) ? 99 : int'($urandom % 100);
         c  = ($urandom % 3 == 0) ? 39 : int'($urandom % 40);
         d  = ($urandom % 2) ? mlen(mo, y) : 1 + int'($urandom % mlen(mo, y));
         seed(i2b(s), i2b(m), i2b(h), i2b(w), i2b(d), i2b(mo), i2b(y), i2b(c));
         n = 1 + int'($urandom % 4);
         for (int k = 0; k < n; k++) begin
            bit t, st;
            t  = ($urandom % 4) != 0;
            st = ($urandom % 6) == 0;
            cyc(t, st, 1'b0);
            cmp_all(st ? "R8 random" : (t ? "R2 R5 random" : "R11 random"));
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule